// File: doc/BRIEF.md
# Board Interrupt Aggregator Register Block

This block gathers sixteen level-sensitive interrupt lines from board peripherals and folds them into one upstream interrupt request. Every line's latest level is tracked in a level vector, which is driven out as per-line outputs. A line whose enable bit is set passes its new level straight to the upstream request, and its index is recorded as a one-hot status value that software reads back.

Software reaches the block over a single-cycle 32-bit register bus whose byte offset spans a 1 MiB window. Besides the enable and status registers, the block holds ten plain storage words used by board firmware: two LED data words, an LED control word, a switch word, three miscellaneous write words, a miscellaneous read word and two card-slot words. The enable and status registers keep only the writable bits given by the mask 0x000FEEFF. A write to the enable register also flips the level vector by the current status value, so firmware can re-arm lines it has already serviced.

Top module: `irq_agg_regs`

## Requirements
- R1: While rst_n is low, and right after it is released, every register reads 0, irq_up is 0 and line_lvl is 0.
- R2: The ten plain words at byte offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88, 0x90, 0xE0 and 0xE4 store all 32 bits of a write and return them on a later read.
- R3: A write to the enable register at offset 0xC0 stores wdata AND 0x000FEEFF; the other bits read 0, so lines 8 and 12 can never be enabled (line i is enabled by bit i).
- R4: A bus write to the status register at offset 0xD0 stores wdata AND 0x000FEEFF when no enabled line changes in that cycle.
- R5: A read with bus_en high and bus_we low at any offset other than the twelve above returns 0, and a write to such an offset changes no register; bus_rdata is 0 whenever no read is requested.
- R6: At the first rising clock edge at which irq_in[i] differs from its value at the edge before, line_lvl[i] takes the new value of irq_in[i], whatever the enable bit.
- R7: At that same edge, if line i is enabled, the status register becomes the one-hot value with only bit i set and irq_up takes the new value of irq_in[i].
- R8: A change on a line that is not enabled leaves the status register and irq_up unchanged.
- R9: When several enabled lines change at the same edge, the lowest-numbered one sets the status register and irq_up.
- R10: A write to the enable register replaces line_lvl with line_lvl XOR the low 16 bits of the status register as it was before that edge.
- R11: When a bus write to the status register and an enabled line change fall on the same edge, the line-driven one-hot value is stored and the bus data is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 20 | Byte offset inside the 1 MiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| irq_in | input | 16 | Level-sensitive interrupt lines |
| irq_up | output | 1 | Upstream interrupt request |
| line_lvl | output | 16 | Tracked level vector, one output per line |

## Verification
A wrong input sample or level vector shows on line_lvl at the very edge where a line changes, and a wrong enable or winner choice shows on irq_up and in the status read-back one edge after the line moves. A status register that drifts stays hidden until the next enable write, when it surfaces as a flipped line_lvl bit on the following edge, so the bench writes the enable register with a known status value and compares the exact vector. Collisions between bus writes and line changes, simultaneous changes on two enabled lines, and changes on the two lines that cannot be enabled are driven on purpose.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DW    = 32;
  localparam int AW    = 20;
  localparam int NLINE = 16;
  localparam int NPLAIN = 10;

  // bits of the enable and status registers that accept writes
  localparam logic [31:0] IRQ_WMASK = 32'h000F_EEFF;

  // byte offsets of the plain storage words
  localparam int unsigned PLAIN_OFS [NPLAIN] = '{
    32'h10, 32'h14, 32'h40, 32'h60, 32'h80,
    32'h84, 32'h88, 32'h90, 32'hE0, 32'hE4
  };
  localparam int unsigned ENA_OFS  = 32'hC0;
  localparam int unsigned STAT_OFS = 32'hD0;
endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
  import irq_agg_pkg::*;
#(
  parameter int AW_P = AW,
  parameter int NP   = NPLAIN
) (
  input  logic [AW_P-1:0] addr,
  output logic [NP-1:0]   hit_plain,
  output logic            hit_ena,
  output logic            hit_stat
);
  for (genvar g = 0; g < NP; g++) begin : g_plain_hit
    assign hit_plain[g] = (addr == AW_P'(PLAIN_OFS[g]));
  end

  assign hit_ena  = (addr == AW_P'(ENA_OFS));
  assign hit_stat = (addr == AW_P'(STAT_OFS));
endmodule

// File: rtl/irq_agg_plain.sv
module irq_agg_plain #(
  parameter int DW_P = 32,
  parameter int NP   = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NP-1:0]          wr_en,
  input  logic [DW_P-1:0]        wdata,
  output logic [NP-1:0][DW_P-1:0] word_q
);
  for (genvar g = 0; g < NP; g++) begin : g_word
    logic [DW_P-1:0] word_d;

    always_comb begin
      word_d = word_q[g];
      if (wr_en[g]) word_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q[g] <= '0;
      else        word_q[g] <= word_d;
    end
  end
endmodule

// File: rtl/irq_agg_tracker.sv
module irq_agg_tracker #(
  parameter int          DW_P  = 32,
  parameter int          NL    = 16,
  parameter logic [31:0] WMASK = 32'h000F_EEFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NL-1:0]   irq_in,
  input  logic            ena_we,
  input  logic            stat_we,
  input  logic [DW_P-1:0] wdata,
  output logic [DW_P-1:0] ena_q,
  output logic [DW_P-1:0] stat_q,
  output logic [NL-1:0]   lvl_q,
  output logic [NL-1:0]   inq_q,
  output logic            up_q
);
  localparam logic [DW_P-1:0] KEEP = DW_P'(WMASK);

  logic [NL-1:0]   chg, fwd, win_oh;
  logic            win_lvl;
  logic [NL-1:0]   lvl_d;
  logic [DW_P-1:0] ena_d, stat_d;
  logic            up_d;

  assign chg = irq_in ^ inq_q;
  assign fwd = chg & ena_q[NL-1:0];

  // lowest-numbered forwarded line wins
  always_comb begin
    win_oh  = '0;
    win_lvl = 1'b0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (fwd[i]) begin
        win_oh  = '0;
        win_oh[i] = 1'b1;
        win_lvl = irq_in[i];
      end
    end
  end

  always_comb begin
    lvl_d = (lvl_q & ~chg) | (irq_in & chg);
    if (ena_we) lvl_d = lvl_d ^ stat_q[NL-1:0];

    ena_d = ena_q;
    if (ena_we) ena_d = wdata & KEEP;

    stat_d = stat_q;
    up_d   = up_q;
    if (|fwd) begin
      stat_d = DW_P'(win_oh);
      up_d   = win_lvl;
    end else if (stat_we) begin
      stat_d = wdata & KEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inq_q  <= '0;
      lvl_q  <= '0;
      ena_q  <= '0;
      stat_q <= '0;
      up_q   <= 1'b0;
    end else begin
      inq_q  <= irq_in;
      lvl_q  <= lvl_d;
      ena_q  <= ena_d;
      stat_q <= stat_d;
      up_q   <= up_d;
    end
  end
endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
  import irq_agg_pkg::*;
#(
  parameter int DW_P = DW,
  parameter int AW_P = AW,
  parameter int NL   = NLINE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_en,
  input  logic            bus_we,
  input  logic [AW_P-1:0] bus_addr,
  input  logic [DW_P-1:0] bus_wdata,
  output logic [DW_P-1:0] bus_rdata,
  input  logic [NL-1:0]   irq_in,
  output logic            irq_up,
  output logic [NL-1:0]   line_lvl
);
  localparam int NP = NPLAIN;

  logic [NP-1:0]           hit_plain;
  logic                    hit_ena, hit_stat;
  logic                    wr_go, rd_go;
  logic [NP-1:0][DW_P-1:0] plain_q;
  logic [DW_P-1:0]         ena_q, stat_q;
  logic [NL-1:0]           inq_q;

  assign wr_go = bus_en & bus_we;
  assign rd_go = bus_en & ~bus_we;

  irq_agg_decode #(.AW_P(AW_P), .NP(NP)) u_dec (
    .addr      (bus_addr),
    .hit_plain (hit_plain),
    .hit_ena   (hit_ena),
    .hit_stat  (hit_stat)
  );

  irq_agg_plain #(.DW_P(DW_P), .NP(NP)) u_plain (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (hit_plain & {NP{wr_go}}),
    .wdata  (bus_wdata),
    .word_q (plain_q)
  );

  irq_agg_tracker #(.DW_P(DW_P), .NL(NL), .WMASK(IRQ_WMASK)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .ena_we  (wr_go & hit_ena),
    .stat_we (wr_go & hit_stat),
    .wdata   (bus_wdata),
    .ena_q   (ena_q),
    .stat_q  (stat_q),
    .lvl_q   (line_lvl),
    .inq_q   (inq_q),
    .up_q    (irq_up)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_go) begin
      for (int i = 0; i < NP; i++) begin
        if (hit_plain[i]) bus_rdata = plain_q[i];
      end
      if (hit_ena)  bus_rdata = ena_q;
      if (hit_stat) bus_rdata = stat_q;
    end
  end
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int DW_P = DW,
  parameter int AW_P = AW,
  parameter int NL   = NLINE
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_en,
  input logic            bus_we,
  input logic [AW_P-1:0] bus_addr,
  input logic [DW_P-1:0] bus_wdata,
  input logic [NL-1:0]   irq_in,
  input logic            irq_up,
  input logic [NL-1:0]   line_lvl,
  input logic [DW_P-1:0] ena_q,
  input logic [DW_P-1:0] stat_q,
  input logic [NL-1:0]   inq_q
);
  logic          ena_wr, stat_wr;
  logic [NL-1:0] fwd;

  assign ena_wr  = bus_en && bus_we && (bus_addr == AW_P'(ENA_OFS));
  assign stat_wr = bus_en && bus_we && (bus_addr == AW_P'(STAT_OFS));
  assign fwd     = (irq_in ^ inq_q) & ena_q[NL-1:0];

  // R3
  ena_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ena_wr |=> ena_q == ($past(bus_wdata) & DW_P'(IRQ_WMASK)));

  // R7 R11
  fwd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd != '0) |=> $countones(stat_q) == 1);

  // R9
  lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd != '0) |=> stat_q[NL-1:0] == $past(fwd & (~fwd + 1'b1)));

  // R8
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd == '0 && !stat_wr) |=> $stable(stat_q) && $stable(irq_up));

  // R6
  lvl_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ena_wr |=> ((line_lvl ^ $past(irq_in)) & $past(irq_in ^ inq_q)) == '0);

  // R10
  ena_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_wr && irq_in == inq_q) |=> line_lvl == $past(line_lvl ^ stat_q[NL-1:0]));
endmodule

bind irq_agg_regs irq_agg_chk #(.DW_P(DW_P), .AW_P(AW_P), .NL(NL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_in    (irq_in),
  .irq_up    (irq_up),
  .line_lvl  (line_lvl),
  .ena_q     (ena_q),
  .stat_q    (stat_q),
  .inq_q     (inq_q)
);

// File: tb/irq_agg_regs_test.sv
module irq_agg_regs_test;
  localparam int NT = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [19:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_in = '0;
  logic        irq_up;
  logic [15:0] line_lvl;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_agg_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_up(irq_up), .line_lvl(line_lvl)
  );

  // address, write value, expected read-back
  localparam logic [19:0] T_ADDR [NT] = '{
    20'h10, 20'h14, 20'h40, 20'h60, 20'h80, 20'h84, 20'h88, 20'h90,
    20'hE0, 20'hE4, 20'hC0, 20'hD0, 20'h44, 20'h11, 20'hFFFFC, 20'hC4
  };
  localparam logic [31:0] T_WR [NT] = '{
    32'hA5A5_0010, 32'h5A5A_0014, 32'hFFFF_FFFF, 32'h1234_5678,
    32'h8000_0001, 32'h0F0F_F0F0, 32'hCAFE_0088, 32'h0000_0090,
    32'hDEAD_BEEF, 32'h7654_3210, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
    32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444
  };
  localparam logic [31:0] T_EXP [NT] = '{
    32'hA5A5_0010, 32'h5A5A_0014, 32'hFFFF_FFFF, 32'h1234_5678,
    32'h8000_0001, 32'h0F0F_F0F0, 32'hCAFE_0088, 32'h0000_0090,
    32'hDEAD_BEEF, 32'h7654_3210, 32'h000F_EEFF, 32'h000F_EEFF,
    32'h0, 32'h0, 32'h0, 32'h0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    irq_in = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_write(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [19:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic drive_irq(input logic [15:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic check_irq(input string req, input logic [31:0] stat_exp,
                           input logic up_exp, input logic [15:0] lvl_exp);
    logic [31:0] rd;
    bus_read(20'hD0, rd);
    check(req, rd, stat_exp);
    check(req, {31'b0, irq_up}, {31'b0, up_exp});
    check(req, {16'b0, line_lvl}, {16'b0, lvl_exp});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    do_reset();
    for (int i = 0; i < 12; i++) begin
      bus_read(T_ADDR[i], rd);
      check("R1", rd, 32'h0);
    end
    check("R1", {31'b0, irq_up}, 32'h0);
    check("R1", {16'b0, line_lvl}, 32'h0);
    bus_read(20'h10, rd);
    check("R5 idle rdata", bus_rdata, 32'h0);

    // table walk: R2 plain words, R3 enable, R4 status, R5 unmapped
    for (int i = 0; i < NT; i++) begin
      bus_write(T_ADDR[i], T_WR[i]);
      bus_read(T_ADDR[i], rd);
      if (i < 10)       check("R2", rd, T_EXP[i]);
      else if (i == 10) check("R3", rd, T_EXP[i]);
      else if (i == 11) check("R4", rd, T_EXP[i]);
      else              check("R5", rd, T_EXP[i]);
    end
    // R5: unmapped writes left every mapped register intact
    for (int i = 0; i < 12; i++) begin
      bus_read(T_ADDR[i], rd);
      check("R5 no side effect", rd, T_EXP[i]);
    end

    // interrupt path
    do_reset();
    drive_irq(16'h0008);                 // R8 line 3 with enable clear
    check_irq("R8 R6", 32'h0, 1'b0, 16'h0008);

    bus_write(20'hC0, 32'h0000_FFFF);
    bus_read(20'hC0, rd);
    check("R3 lines 8 and 12 locked", rd, 32'h0000_EEFF);
    check("R10 zero status", {16'b0, line_lvl}, 32'h0008);

    drive_irq(16'h0028);                 // R7 line 5 rises
    check_irq("R7 rise", 32'h20, 1'b1, 16'h0028);
    drive_irq(16'h0008);                 // R7 line 5 falls
    check_irq("R7 fall", 32'h20, 1'b0, 16'h0008);
    drive_irq(16'h0108);                 // R3 R8 line 8 cannot be enabled
    check_irq("R8 line 8", 32'h20, 1'b0, 16'h0108);
    drive_irq(16'h030C);                 // R9 lines 2 and 9 together
    check_irq("R9", 32'h4, 1'b1, 16'h030C);
    drive_irq(16'h010C);                 // line 9 falls
    check_irq("R7 line 9", 32'h200, 1'b0, 16'h010C);

    bus_write(20'hC0, 32'h0);            // R10 flip by 0x200
    check("R10 flip", {16'b0, line_lvl}, 32'h030C);
    bus_write(20'hC0, 32'h0000_FFFF);
    check("R10 flip back", {16'b0, line_lvl}, 32'h010C);

    // R11: bus write to status collides with enabled line 0 rising
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 20'hD0; bus_wdata = 32'h0000_ABCD;
    irq_in = 16'h010D;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    check_irq("R11", 32'h1, 1'b1, 16'h010D);

    drive_irq(16'h000D);                 // R8 line 8 falls, irq_up held high
    check_irq("R8 hold high", 32'h1, 1'b1, 16'h000D);

    bus_write(20'hD0, 32'hFFFF_FFFF);    // R4 bus write with quiet lines
    check_irq("R4", 32'h000F_EEFF, 1'b1, 16'h000D);

    bus_write(20'hC0, 32'h0000_FFFF);    // R10 flip by 0xEEFF
    check("R10 wide flip", {16'b0, line_lvl}, 32'hEEF2);

    do_reset();                          // R1 after activity
    check_irq("R1 again", 32'h0, 1'b0, 16'h0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule